// File: doc/BRIEF.md
# Predicated Floating-Point Compare Unit

This block compares two IEEE-754 operands, either both binary32 or both binary64, and reduces the outcome to a single condition bit. A precision-select input chooses the format. A 3-bit predicate code picks one of eight tests on the raw relation. The raw relation is one of less, equal, greater or unordered, and four of the eight predicates also accept the unordered case. The comparison is quiet. A NaN operand yields unordered. Only a signalling NaN raises a separate invalid indication.

Each compare is launched by a one-cycle valid strobe. One clock later the block registers the condition bit, the invalid indication and a rewritten status word, and raises a done pulse. The status word is formed from the caller's current status input as follows:
- the condition bit goes into bit 29;
- the rest of the top nibble is cleared;
- the low 28 bits pass through unchanged.

This lets the surrounding pipeline write the status word straight back.

Top module: `fcmp_pred_unit`

## Requirements
- R1: While rst_ni is low, flag_o, inv_o and done_o are 0 and stat_o is all zeros.
- R2: A compare presented with valid_i high at a rising edge updates flag_o, inv_o and stat_o at that edge, and done_o is high for exactly that one following cycle. Without valid_i, done_o is 0 and flag_o, inv_o and stat_o hold their values even if the other inputs change.
- R3: Predicate codes 0 to 3 behave as follows: code 0 always gives 0; code 1 is true only on unordered; code 2 is true only on equal; code 3 is true on equal or unordered.
- R4: Predicate codes 4 to 7 behave as follows: code 4 is true only on less; code 5 is true on less or unordered; code 6 is true on less or equal; code 7 is true on everything except greater.
- R5: Only cond_i[2:0] selects the predicate. Higher bits of cond_i have no effect.
- R6: Any NaN operand (exponent all ones, mantissa nonzero) makes the relation unordered. A signalling NaN (mantissa MSB 0) sets inv_o to 1. A quiet NaN (mantissa MSB 1) leaves inv_o at 0.
- R7: +0 and -0 compare equal. Infinities order by sign. Among negative numbers, the larger magnitude is the lesser value.
- R8: With dbl_i=1 the full 64-bit operands are compared as binary64. With dbl_i=0 only a_i[31:0] and b_i[31:0] are compared as binary32, and the upper halves are ignored.
- R9: On each compare, stat_o takes the following values: bit 29 equals the new flag_o; bits 31, 30 and 28 are 0; bits 27:0 equal stat_i[27:0] sampled with valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Launch a compare this cycle |
| dbl_i | input | 1 | 1 = binary64 operands, 0 = binary32 in low halves |
| cond_i | input | COND_W (4) | Predicate code, low 3 bits used |
| a_i | input | 64 | Left operand |
| b_i | input | 64 | Right operand |
| stat_i | input | STAT_W (32) | Current status word |
| flag_o | output | 1 | Registered predicate result |
| inv_o | output | 1 | Registered signalling-NaN indication |
| done_o | output | 1 | One-cycle pulse when a result is registered |
| stat_o | output | STAT_W (32) | Registered updated status word |

## Verification
The bench builds the block with its default parameters:
- binary32 and binary64 field widths;
- a 4-bit condition input;
- a 32-bit status word with the flag at bit 29.

The spare top bit of cond_i therefore exists and can be driven, which makes the rule that it is ignored checkable. With the standard field widths, hand-encoded constants reach the corner cases directly: signed zeros, infinities of either sign, signalling and quiet NaNs in both formats, and negative operands. Garbage in the upper operand halves during binary32 compares shows that the unused bits are ignored.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef enum logic [2:0] {
    P_NEVER = 3'd0,
    P_UN    = 3'd1,
    P_EQ    = 3'd2,
    P_UEQ   = 3'd3,
    P_LT    = 3'd4,
    P_ULT   = 3'd5,
    P_LE    = 3'd6,
    P_ULE   = 3'd7
  } pred_e;

  typedef struct packed {
    rel_e rel;
    logic snan;
  } cmp_res_t;
endpackage

// File: rtl/fcmp_class.sv
module fcmp_class #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int OW = EXP_W + MAN_W + 1
) (
  input  logic [OW-1:0] op_i,
  output logic          nan_o,
  output logic          snan_o,
  output logic          zero_o
);
  logic [EXP_W-1:0] exp_w;
  logic [MAN_W-1:0] man_w;

  assign exp_w  = op_i[OW-2:MAN_W];
  assign man_w  = op_i[MAN_W-1:0];
  assign nan_o  = (&exp_w) & (|man_w);
  // MSB of mantissa clear marks a signalling NaN
  assign snan_o = nan_o & ~man_w[MAN_W-1];
  assign zero_o = ~|op_i[OW-2:0];
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int OW = EXP_W + MAN_W + 1
) (
  input  logic [OW-1:0] a_i,
  input  logic [OW-1:0] b_i,
  output cmp_res_t      res_o
);
  logic a_nan, a_snan, a_zero;
  logic b_nan, b_snan, b_zero;
  logic sa, sb, mag_lt, mag_eq;

  fcmp_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
    .op_i(a_i), .nan_o(a_nan), .snan_o(a_snan), .zero_o(a_zero)
  );
  fcmp_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
    .op_i(b_i), .nan_o(b_nan), .snan_o(b_snan), .zero_o(b_zero)
  );

  assign sa     = a_i[OW-1];
  assign sb     = b_i[OW-1];
  assign mag_lt = a_i[OW-2:0] < b_i[OW-2:0];
  assign mag_eq = a_i[OW-2:0] == b_i[OW-2:0];

  always_comb begin
    res_o.snan = a_snan | b_snan;
    if (a_nan | b_nan)          res_o.rel = REL_UN;
    else if (a_zero & b_zero)   res_o.rel = REL_EQ;
    else if (sa != sb)          res_o.rel = sa ? REL_LT : REL_GT;
    else if (mag_eq)            res_o.rel = REL_EQ;
    // negative operands reverse magnitude order
    else if (mag_lt ^ sa)       res_o.rel = REL_LT;
    else                        res_o.rel = REL_GT;
  end
endmodule

// File: rtl/fcmp_pred_sel.sv
module fcmp_pred_sel
  import fcmp_pkg::*;
(
  input  rel_e        rel_i,
  input  logic [2:0]  code_i,
  output logic        hit_o
);
  logic is_lt, is_eq, is_gt, is_un;

  assign is_lt = rel_i == REL_LT;
  assign is_eq = rel_i == REL_EQ;
  assign is_gt = rel_i == REL_GT;
  assign is_un = rel_i == REL_UN;

  always_comb begin
    unique case (pred_e'(code_i))
      P_NEVER: hit_o = 1'b0;
      P_UN:    hit_o = is_un;
      P_EQ:    hit_o = is_eq;
      P_UEQ:   hit_o = is_eq | is_un;
      P_LT:    hit_o = is_lt;
      P_ULT:   hit_o = is_lt | is_un;
      P_LE:    hit_o = is_lt | is_eq;
      P_ULE:   hit_o = ~is_gt;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcmp_pred_unit.sv
module fcmp_pred_unit
  import fcmp_pkg::*;
#(
  parameter int SP_EXP   = 8,
  parameter int SP_MAN   = 23,
  parameter int DP_EXP   = 11,
  parameter int DP_MAN   = 52,
  parameter int COND_W   = 4,
  parameter int STAT_W   = 32,
  parameter int FLAG_POS = 29,
  parameter int CLR_LO   = 28,
  localparam int DW = DP_EXP + DP_MAN + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              dbl_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              flag_o,
  output logic              inv_o,
  output logic              done_o,
  output logic [STAT_W-1:0] stat_o
);
  cmp_res_t          res_w [2];
  cmp_res_t          res_sel;
  logic              hit;
  logic [STAT_W-1:0] stat_nx;

  // index 0: single, index 1: double
  for (genvar gi = 0; gi < 2; gi++) begin : g_fmt
    localparam int EW = (gi == 0) ? SP_EXP : DP_EXP;
    localparam int MW = (gi == 0) ? SP_MAN : DP_MAN;
    localparam int OW = EW + MW + 1;
    fcmp_order #(.EXP_W(EW), .MAN_W(MW)) u_ord (
      .a_i  (a_i[OW-1:0]),
      .b_i  (b_i[OW-1:0]),
      .res_o(res_w[gi])
    );
  end

  assign res_sel = dbl_i ? res_w[1] : res_w[0];

  fcmp_pred_sel u_sel (
    .rel_i (res_sel.rel),
    .code_i(cond_i[2:0]),
    .hit_o (hit)
  );

  always_comb begin
    stat_nx                   = stat_i;
    stat_nx[STAT_W-1:CLR_LO]  = '0;
    stat_nx[FLAG_POS]         = hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      inv_o  <= 1'b0;
      done_o <= 1'b0;
      stat_o <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        flag_o <= hit;
        inv_o  <= res_sel.snan;
        stat_o <= stat_nx;
      end
    end
  end
endmodule

// File: rtl/fcmp_pred_chk.sv
module fcmp_pred_chk #(
  parameter int COND_W   = 4,
  parameter int STAT_W   = 32,
  parameter int FLAG_POS = 29,
  parameter int CLR_LO   = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [COND_W-1:0] cond_i,
  input logic [STAT_W-1:0] stat_i,
  input logic              flag_o,
  input logic              inv_o,
  input logic              done_o,
  input logic [STAT_W-1:0] stat_o
);
  // R2
  done_follows_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  // R2
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  // R2
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(flag_o) && $stable(inv_o) && $stable(stat_o)));
  // R3
  never_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i[2:0] == 3'd0) |=> !flag_o);
  // R9
  stat_flag_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (stat_o[FLAG_POS] == flag_o));
  // R9
  stat_low_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (stat_o[CLR_LO-1:0] == $past(stat_i[CLR_LO-1:0])));
  // R9
  stat_hi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones(stat_o[STAT_W-1:CLR_LO]) == (flag_o ? 1 : 0)));
endmodule

bind fcmp_pred_unit fcmp_pred_chk #(
  .COND_W(COND_W), .STAT_W(STAT_W), .FLAG_POS(FLAG_POS), .CLR_LO(CLR_LO)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .cond_i (cond_i),
  .stat_i (stat_i),
  .flag_o (flag_o),
  .inv_o  (inv_o),
  .done_o (done_o),
  .stat_o (stat_o)
);

// File: tb/sim_fcmp_pred_unit.sv
`timescale 1ns/1ps
module sim_fcmp_pred_unit;
  localparam int LT = 0, EQ = 1, GT = 2, UN = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        dbl_i = 1'b0;
  logic [3:0]  cond_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [31:0] stat_i = '0;
  logic        flag_o, inv_o, done_o;
  logic [31:0] stat_o;

  int n_chk = 0;
  int n_err = 0;
  bit ended = 0;

  always #10 clk_i = ~clk_i;

  fcmp_pred_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .dbl_i(dbl_i),
    .cond_i(cond_i), .a_i(a_i), .b_i(b_i), .stat_i(stat_i),
    .flag_o(flag_o), .inv_o(inv_o), .done_o(done_o), .stat_o(stat_o)
  );

  function automatic bit pred(input int code, input int rel);
    case (code)
      0: return 1'b0;
      1: return rel == UN;
      2: return rel == EQ;
      3: return rel == EQ || rel == UN;
      4: return rel == LT;
      5: return rel == LT || rel == UN;
      6: return rel == LT || rel == EQ;
      default: return rel != GT;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input bit dbl, input logic [3:0] cond,
                        input logic [31:0] st, input int rel,
                        input bit inv_exp, input string req);
    bit f;
    @(negedge clk_i);
    a_i = a; b_i = b; dbl_i = dbl; cond_i = cond; stat_i = st; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    f = pred(int'(cond[2:0]), rel);
    chk(req, "flag", {63'd0, flag_o}, {63'd0, f});
    chk(req, "inv", {63'd0, inv_o}, {63'd0, inv_exp});
    chk("R2", "done", {63'd0, done_o}, 64'd1);
    chk("R9", "stat", {32'd0, stat_o}, {32'd0, 2'b00, f, 1'b0, st[27:0]});
  endtask

  task automatic t_reset;
    chk("R1", "flag", {63'd0, flag_o}, 64'd0);
    chk("R1", "inv", {63'd0, inv_o}, 64'd0);
    chk("R1", "done", {63'd0, done_o}, 64'd0);
    chk("R1", "stat", {32'd0, stat_o}, 64'd0);
  endtask

  task automatic t_codes_single;
    for (int c = 0; c < 8; c++) begin
      run_op(64'h3f800000, 64'h40000000, 0, 4'(c), 32'h0, LT, 0, c < 4 ? "R3" : "R4");
      run_op(64'h40000000, 64'h40000000, 0, 4'(c), 32'h0, EQ, 0, c < 4 ? "R3" : "R4");
      run_op(64'h40000000, 64'h3f800000, 0, 4'(c), 32'h0, GT, 0, c < 4 ? "R3" : "R4");
      run_op(64'h7fc00000, 64'h3f800000, 0, 4'(c), 32'h0, UN, 0, c < 4 ? "R3" : "R4");
    end
  endtask

  task automatic t_codes_double;
    for (int c = 0; c < 8; c++) begin
      run_op(64'h3ff0000000000000, 64'h4000000000000000, 1, 4'(c), 32'h0, LT, 0, "R8");
      run_op(64'h4000000000000000, 64'h3ff0000000000000, 1, 4'(c), 32'h0, GT, 0, "R8");
      run_op(64'h3ff0000000000000, 64'h7ff8000000000000, 1, 4'(c), 32'h0, UN, 0, "R8");
    end
  endtask

  task automatic t_sign_zero_inf;
    run_op(64'h00000000, 64'h80000000, 0, 4'd2, 32'h0, EQ, 0, "R7");
    run_op(64'h8000000000000000, 64'h0, 1, 4'd6, 32'h0, EQ, 0, "R7");
    run_op(64'hc0000000, 64'hbf800000, 0, 4'd4, 32'h0, LT, 0, "R7");
    run_op(64'hbff0000000000000, 64'hc000000000000000, 1, 4'd4, 32'h0, GT, 0, "R7");
    run_op(64'h7f800000, 64'hff800000, 0, 4'd7, 32'h0, GT, 0, "R7");
    run_op(64'hff800000, 64'hff800000, 0, 4'd2, 32'h0, EQ, 0, "R7");
    run_op(64'hfff0000000000000, 64'hc000000000000000, 1, 4'd4, 32'h0, LT, 0, "R7");
  endtask

  task automatic t_nan;
    run_op(64'h7f800001, 64'h3f800000, 0, 4'd1, 32'h0, UN, 1, "R6");
    run_op(64'h3f800000, 64'hffc00001, 0, 4'd1, 32'h0, UN, 0, "R6");
    run_op(64'h7ff0000000000001, 64'h0, 1, 4'd3, 32'h0, UN, 1, "R6");
    run_op(64'h7ff8000000000000, 64'h7ff8000000000000, 1, 4'd2, 32'h0, UN, 0, "R6");
    run_op(64'h7f800000, 64'h7f800000, 0, 4'd1, 32'h0, EQ, 0, "R6");
  endtask

  task automatic t_cond_high;
    run_op(64'h40000000, 64'h40000000, 0, 4'b1010, 32'h0, EQ, 0, "R5");
    run_op(64'h40000000, 64'h40000000, 0, 4'b1000, 32'h0, EQ, 0, "R5");
    run_op(64'h3f800000, 64'h40000000, 0, 4'b1100, 32'h0, LT, 0, "R5");
  endtask

  task automatic t_upper_ignored;
    run_op(64'h7ff80000_3f800000, 64'h12345678_40000000, 0, 4'd4, 32'h0, LT, 0, "R8");
    run_op(64'hdeadbeef_40000000, 64'h00000001_40000000, 0, 4'd2, 32'h0, EQ, 0, "R8");
  endtask

  task automatic t_status;
    run_op(64'h40000000, 64'h40000000, 0, 4'd2, 32'hffffffff, EQ, 0, "R9");
    chk("R9", "stat_set", {32'd0, stat_o}, 64'h2fffffff);
    run_op(64'h40000000, 64'h40000000, 0, 4'd4, 32'hd5a5a5a5, EQ, 0, "R9");
    chk("R9", "stat_clr", {32'd0, stat_o}, 64'h05a5a5a5);
  endtask

  task automatic t_hold;
    run_op(64'h3f800000, 64'h40000000, 0, 4'd4, 32'h0abcdef1, LT, 0, "R2");
    @(negedge clk_i);
    a_i = 64'h7f800001; b_i = 64'h0; cond_i = 4'd0; stat_i = 32'hffffffff;
    @(negedge clk_i);
    chk("R2", "done_low", {63'd0, done_o}, 64'd0);
    chk("R2", "flag_hold", {63'd0, flag_o}, 64'd1);
    chk("R2", "inv_hold", {63'd0, inv_o}, 64'd0);
    chk("R2", "stat_hold", {32'd0, stat_o}, 64'h2abcdef1);
  endtask

  initial begin
    #(200000 * 20);
    if (!ended) begin
      ended = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_codes_single();
    t_codes_double();
    t_sign_zero_inf();
    t_nan();
    t_cond_high();
    t_upper_ignored();
    t_status();
    t_hold();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule